// File: doc/BRIEF.md
# SPI Device Register Bank

This block is the control and status register file that sits behind the peripheral-side command decoder of an SPI slave. The decoder presents a byte address, a write strobe and a write byte. The bank returns the addressed byte combinationally on its read port. It holds the link configuration, the read-response delays, the status-reporting options, the backplane reset control, an interrupt status and mask pair, a 32-bit transfer status word, three function info words, a fixed signature and a scratch word. Multi-byte registers are little-endian: the lowest offset holds bits 7:0.

Interrupt bits come from one 16-bit hardware source input. Bits 0 (data unavailable), 3 (command error) and 4 (data error) are sticky. A pulse on the source sets them, and the host clears them by writing a one. Every other bit is a registered copy of its source level. One interrupt pin reports any unmasked pending bit, at a polarity chosen by configuration bit 5.

A small state machine handles the reset trigger. It has two states. In `RST_IDLE` no pulse is driven. A write to offset 0x03 with bit 7 set takes the transition *trigger* to `RST_FIRE`. For that one cycle, each backplane reset output whose enable bit was written as one pulses high, and bit 7 reads back as one. Without a new trigger write, the transition *expire* returns the machine to `RST_IDLE`. A new trigger write in `RST_FIRE` takes *retrigger* and the machine stays in `RST_FIRE`.

Top module: `spi_dev_regbank`

## Requirements
- R1: A read returns, combinationally, the byte at `addr_i`; multi-byte registers are little-endian; offsets 0x12, 0x13 read 0x00.
- R2: Offsets 0x14..0x17 always read 0xAD, 0xBE, 0xED, 0xFE (signature 0xFEEDBEAD), and writes there change nothing.
- R3: Writable registers store the written byte under a mask: 0x00 configuration mask 0xBF, 0x01 response delay 0xFF, 0x02 status-enable mask 0x6F, 0x03 enables mask 0x0C (bit 2 first backplane, bit 3 second), 0x06..0x07 interrupt mask, 0x18..0x1B scratch, 0x1C..0x1F per-function delays, all full bytes.
- R4: Offsets 0x08..0x0B read `xfer_status_i`; 0x0C, 0x0E and 0x10 read function 1, 2 and 3 info from `fn_info_i` (16 bits each, function 1 in bits 15:0), masked with 0x01FF for function 1 and 0x3FFF for the others; writes to these offsets are ignored.
- R5: Interrupt status bits 0, 3, 4 (read at 0x04) set one cycle after their source bit is high and stay set; writing a 1 to such a bit position at 0x04 clears it, writing 0 leaves it.
- R6: When a source pulse and a write-one-to-clear hit the same sticky bit in the same cycle, the bit ends set.
- R7: All other interrupt status bits equal their source bit of the previous cycle; host writes to them have no effect.
- R8: `irq_o` is the OR of (status AND mask), driven high-true when configuration bit 5 is 1 and low-true when it is 0.
- R9: Writing 0x03 with bit 7 set drives `wlan_rst_o` and `bt_rst_o` high for exactly the following cycle, each only if its enable bit (2, resp. 3) was set by that write; bit 7 of 0x03 reads 1 during that cycle and 0 afterwards.
- R10: After reset all writable registers and interrupt bits are zero, `irq_o` is high (inactive for the reset polarity) and no reset pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed byte |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte at `addr_i` |
| xfer_status_i | input | 32 | Transfer status word from the transfer engine |
| fn_info_i | input | 48 | Info words of functions 1..3 |
| irq_src_i | input | 16 | Interrupt source events and levels |
| irq_o | output | 1 | Interrupt pin, programmable polarity |
| wlan_rst_o | output | 1 | First backplane reset pulse |
| bt_rst_o | output | 1 | Second backplane reset pulse |

## Verification
The hardest case to reach from the ports is the same-cycle collision. A source pulse on a sticky bit has to coincide with a host write-one-to-clear on that bit, and it has to happen while the bit is already set. A close second is a retrigger write that lands during the single `RST_FIRE` cycle. The directed stimulus sets a sticky bit first and then issues the clearing write with the source still pulsing. It then writes the trigger on two consecutive cycles with different enable patterns. A long random phase then weights its addresses toward 0x03 and 0x04 and keeps sticky pulses sparse, so that these collisions recur against the reference model.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        RST_IDLE = 1'b0,
        RST_FIRE = 1'b1
    } rst_state_e;

    // byte offsets whose position the command decoder depends on
    localparam int OFF_CFG    = 'h00;
    localparam int OFF_RDLY   = 'h01;
    localparam int OFF_SEN    = 'h02;
    localparam int OFF_RCTL   = 'h03;
    localparam int OFF_ISTAT  = 'h04;
    localparam int OFF_IMASK  = 'h06;
    localparam int OFF_XSTAT  = 'h08;
    localparam int OFF_FINFO  = 'h0C;
    localparam int OFF_SIG    = 'h14;
    localparam int OFF_SCR    = 'h18;
    localparam int OFF_FDLY   = 'h1C;

    localparam logic [7:0]  CFG_WMASK   = 8'hBF;
    localparam logic [7:0]  SEN_WMASK   = 8'h6F;
    localparam int          POL_BIT     = 5;
    localparam int          EN_A_BIT    = 2;
    localparam int          EN_B_BIT    = 3;
    localparam int          TRIG_BIT    = 7;
    localparam logic [15:0] STICKY_BITS = 16'h0019;
    localparam logic [31:0] SIGNATURE   = 32'hFEED_BEAD;
    localparam logic [15:0] INFO1_MASK  = 16'h01FF;
    localparam logic [15:0] INFOX_MASK  = 16'h3FFF;

endpackage

// File: rtl/spi_regbank_irq.sv
module spi_regbank_irq #(
    parameter int          IRQ_W  = 16,
    parameter logic [15:0] STICKY = 16'h0019
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] src_i,
    input  logic [IRQ_W-1:0] clr_i,
    input  logic [IRQ_W-1:0] mask_i,
    input  logic             pol_high_i,
    output logic [IRQ_W-1:0] stat_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] stat_q;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            // a set event beats a same-cycle clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         stat_q[i] <= 1'b0;
                else if (src_i[i])  stat_q[i] <= 1'b1;
                else if (clr_i[i])  stat_q[i] <= 1'b0;
            end
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[i] <= 1'b0;
                else        stat_q[i] <= src_i[i];
            end
        end
    end

    logic pending;
    always_comb begin
        pending = |(stat_q & mask_i);
        irq_o   = pol_high_i ? pending : ~pending;
        stat_o  = stat_q;
    end
endmodule

// File: rtl/spi_regbank_rstctl.sv
module spi_regbank_rstctl
    import spi_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic en_a_i,
    input  logic en_b_i,
    output logic firing_o,
    output logic rst_a_o,
    output logic rst_b_o
);
    rst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE: if (trig_i) state_d = RST_FIRE;   // trigger
            RST_FIRE: if (!trig_i) state_d = RST_IDLE;  // expire (else retrigger)
            default:  state_d = RST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        firing_o = 1'b0;
        rst_a_o  = 1'b0;
        rst_b_o  = 1'b0;
        unique case (state_q)
            RST_IDLE: ;
            RST_FIRE: begin
                firing_o = 1'b1;
                rst_a_o  = en_a_i;
                rst_b_o  = en_b_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_regbank_rdmux.sv
module spi_regbank_rdmux #(
    parameter int ADDR_W = 5,
    localparam int NBYTES = 1 << ADDR_W
) (
    input  logic [NBYTES*8-1:0] image_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [7:0]          rdata_o
);
    always_comb rdata_o = image_i[8*addr_i +: 8];
endmodule

// File: rtl/spi_dev_regbank.sv
module spi_dev_regbank
    import spi_regbank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int IRQ_W  = 16,
    parameter int XST_W  = 32,
    parameter int INFO_W = 16,
    parameter int NINFO  = 3,
    parameter int NDLY   = 4,
    parameter int SCR_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [7:0]              wdata_i,
    output logic [7:0]              rdata_o,
    input  logic [XST_W-1:0]        xfer_status_i,
    input  logic [NINFO*INFO_W-1:0] fn_info_i,
    input  logic [IRQ_W-1:0]        irq_src_i,
    output logic                    irq_o,
    output logic                    wlan_rst_o,
    output logic                    bt_rst_o
);
    localparam int NBYTES   = 1 << ADDR_W;
    localparam int IRQ_B    = IRQ_W / 8;
    localparam int XST_B    = XST_W / 8;
    localparam int INFO_B   = INFO_W / 8;
    localparam int SCR_B    = SCR_W / 8;
    localparam int SIG_B    = 4;

    logic [7:0]       cfg_q, rdly_q, sen_q;
    logic [1:0]       ren_q;
    logic [IRQ_W-1:0] mask_q;
    logic [SCR_W-1:0] scr_q;
    logic [7:0]       fdly_q [NDLY];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    // writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            rdly_q <= '0;
            sen_q  <= '0;
            ren_q  <= '0;
            mask_q <= '0;
            scr_q  <= '0;
            for (int k = 0; k < NDLY; k++) fdly_q[k] <= '0;
        end else if (wr_en) begin
            if (hit(addr_i, OFF_CFG))  cfg_q  <= wdata_i & CFG_WMASK;
            if (hit(addr_i, OFF_RDLY)) rdly_q <= wdata_i;
            if (hit(addr_i, OFF_SEN))  sen_q  <= wdata_i & SEN_WMASK;
            if (hit(addr_i, OFF_RCTL)) ren_q  <= {wdata_i[EN_B_BIT], wdata_i[EN_A_BIT]};
            for (int k = 0; k < IRQ_B; k++)
                if (hit(addr_i, OFF_IMASK + k)) mask_q[8*k +: 8] <= wdata_i;
            for (int k = 0; k < SCR_B; k++)
                if (hit(addr_i, OFF_SCR + k)) scr_q[8*k +: 8] <= wdata_i;
            for (int k = 0; k < NDLY; k++)
                if (hit(addr_i, OFF_FDLY + k)) fdly_q[k] <= wdata_i;
        end
    end

    // write-one-to-clear lanes of the interrupt status
    logic [IRQ_W-1:0] irq_clr;
    always_comb begin
        irq_clr = '0;
        for (int k = 0; k < IRQ_B; k++)
            if (wr_en && hit(addr_i, OFF_ISTAT + k)) irq_clr[8*k +: 8] = wdata_i;
    end

    logic [IRQ_W-1:0] irq_stat;
    spi_regbank_irq #(
        .IRQ_W  (IRQ_W),
        .STICKY (STICKY_BITS)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (irq_src_i),
        .clr_i      (irq_clr),
        .mask_i     (mask_q),
        .pol_high_i (cfg_q[POL_BIT]),
        .stat_o     (irq_stat),
        .irq_o      (irq_o)
    );

    logic trig, firing;
    assign trig = wr_en && hit(addr_i, OFF_RCTL) && wdata_i[TRIG_BIT];

    spi_regbank_rstctl u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .en_a_i   (ren_q[0]),
        .en_b_i   (ren_q[1]),
        .firing_o (firing),
        .rst_a_o  (wlan_rst_o),
        .rst_b_o  (bt_rst_o)
    );

    // read image, one byte per offset
    logic [NBYTES*8-1:0] image;
    logic [INFO_W-1:0]   info_m;
    always_comb begin
        image = '0;
        image[8*OFF_CFG  +: 8] = cfg_q;
        image[8*OFF_RDLY +: 8] = rdly_q;
        image[8*OFF_SEN  +: 8] = sen_q;
        image[8*OFF_RCTL +: 8] = {firing, 3'b000, ren_q[1], ren_q[0], 2'b00};
        image[8*OFF_ISTAT +: IRQ_W] = irq_stat;
        image[8*OFF_IMASK +: IRQ_W] = mask_q;
        image[8*OFF_XSTAT +: XST_W] = xfer_status_i;
        info_m = '0;
        for (int f = 0; f < NINFO; f++) begin
            info_m = fn_info_i[INFO_W*f +: INFO_W] & ((f == 0) ? INFO1_MASK : INFOX_MASK);
            image[8*(OFF_FINFO + INFO_B*f) +: INFO_W] = info_m;
        end
        image[8*OFF_SIG +: 8*SIG_B] = SIGNATURE;
        image[8*OFF_SCR +: SCR_W]   = scr_q;
        for (int k = 0; k < NDLY; k++) image[8*(OFF_FDLY + k) +: 8] = fdly_q[k];
    end

    spi_regbank_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .image_i (image),
        .addr_i  (addr_i),
        .rdata_o (rdata_o)
    );

    logic unused_ok;
    assign unused_ok = ^{XST_B, 1'b0};
endmodule

// File: rtl/spi_dev_regbank_chk.sv
module spi_dev_regbank_chk
    import spi_regbank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  addr_i,
    input logic [7:0]  wdata_i,
    input logic [7:0]  rdata_o,
    input logic [15:0] irq_src_i,
    input logic [15:0] irq_stat,
    input logic [15:0] mask_q,
    input logic [7:0]  cfg_q,
    input logic        irq_o,
    input logic        wlan_rst_o,
    input logic        bt_rst_o
);
    p_signature_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 5'h14) |-> (rdata_o == 8'hAD));

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == 5'h04 && wdata_i[0] && !irq_src_i[0]) |=> !irq_stat[0]);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_src_i & STICKY_BITS) != 16'h0) |=>
        ((irq_stat & $past(irq_src_i & STICKY_BITS)) == $past(irq_src_i & STICKY_BITS)));

    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irq_stat & ~STICKY_BITS) == ($past(irq_src_i) & ~STICKY_BITS)));

    p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_stat & mask_q) == 16'h0) |-> (irq_o == !cfg_q[POL_BIT]));

    p_pulse_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == 5'h03 && wdata_i[7]) |=>
        (wlan_rst_o == $past(wdata_i[2]) && bt_rst_o == $past(wdata_i[3])));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((wlan_rst_o || bt_rst_o) && !(wr_en && addr_i == 5'h03 && wdata_i[7]))
        |=> (!wlan_rst_o && !bt_rst_o));
endmodule

bind spi_dev_regbank spi_dev_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_src_i  (irq_src_i),
    .irq_stat   (irq_stat),
    .mask_q     (mask_q),
    .cfg_q      (cfg_q),
    .irq_o      (irq_o),
    .wlan_rst_o (wlan_rst_o),
    .bt_rst_o   (bt_rst_o)
);

// File: tb/spi_dev_regbank_bench.sv
module spi_dev_regbank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [31:0] xstat = '0;
    logic [47:0] finfo = '0;
    logic [15:0] src = '0;
    logic        irq, rst_a, rst_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dev_regbank u_spi_dev_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .xfer_status_i(xstat), .fn_info_i(finfo), .irq_src_i(src),
        .irq_o(irq), .wlan_rst_o(rst_a), .bt_rst_o(rst_b)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [7:0]  m_reg [32];
    logic [15:0] m_int;
    string       tag_ovr = "";

    function automatic logic [7:0] wmask(input int a);
        if (a == 0) return 8'hBF;
        if (a == 2) return 8'h6F;
        if (a == 3) return 8'h8C;
        if (a == 1 || a == 6 || a == 7 || a >= 24) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        logic [31:0] sig = 32'hFEEDBEAD;
        logic [15:0] inf;
        if (a == 4) return m_int[7:0];
        if (a == 5) return m_int[15:8];
        if (a >= 8 && a <= 11) return xstat[8*(a-8) +: 8];
        if (a >= 12 && a <= 17) begin
            inf = finfo[16*((a-12)/2) +: 16] & ((a < 14) ? 16'h01FF : 16'h3FFF);
            return inf[8*((a-12)%2) +: 8];
        end
        if (a >= 20 && a <= 23) return sig[8*(a-20) +: 8];
        return m_reg[a];
    endfunction

    function automatic string req_of(input int a);
        if (tag_ovr != "") return tag_ovr;
        if (a == 4 || a == 5) return "R5";
        if (a >= 8 && a <= 17) return "R4";
        if (a >= 20 && a <= 23) return "R2";
        if (a == 18 || a == 19) return "R1";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h, t=%0t)", tag, act, exp, addr, $time);
        end
    endtask

    task automatic compare();
        logic [15:0] pend = m_int & {m_reg[7], m_reg[6]};
        logic        lvl  = m_reg[0][5] ? (pend != 0) : (pend == 0);
        chk(req_of(int'(addr)), rdata, exp_rd(int'(addr)));
        chk((tag_ovr != "") ? tag_ovr : "R8", irq, lvl);
        chk("R9 wlan", rst_a, m_reg[3][7] & m_reg[3][2]);
        chk("R9 bt", rst_b, m_reg[3][7] & m_reg[3][3]);
    endtask

    task automatic model_step();
        logic [15:0] clr = 16'h0;
        if (wr_en && addr == 5'd4) clr[7:0] = wdata;
        if (wr_en && addr == 5'd5) clr[15:8] = wdata;
        for (int i = 0; i < 16; i++) begin
            if (16'h0019 & (16'h1 << i)) begin
                if (src[i])      m_int[i] = 1'b1;
                else if (clr[i]) m_int[i] = 1'b0;
            end else begin
                m_int[i] = src[i];
            end
        end
        if (!(wr_en && addr == 5'd3)) m_reg[3][7] = 1'b0;
        if (wr_en) m_reg[addr] = (wdata & wmask(int'(addr))) | (m_reg[addr] & ~wmask(int'(addr)));
    endtask

    // one clock: drive at negedge, compare, advance the model
    task automatic cyc(input logic w, input int a, input logic [7:0] d, input logic [15:0] s);
        @(negedge clk);
        wr_en = w; addr = 5'(a); wdata = d; src = s;
        #1;
        compare();
        model_step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
        m_int = '0;
        xstat = 32'h8421_5A3C;
        finfo = 48'hFFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state swept over every offset
        tag_ovr = "R10";
        for (int a = 0; a < 32; a++) cyc(1'b0, a, 8'h00, 16'h0);
        chk("R10 irq idle", irq, 1'b1);
        tag_ovr = "";

        // R3 / R2 / R4: write every offset with 0xFF, read back
        for (int a = 0; a < 32; a++) cyc(1'b1, a, 8'hFF, 16'h0);
        for (int a = 0; a < 32; a++) cyc(1'b0, a, 8'h00, 16'h0);
        for (int a = 0; a < 32; a++) cyc(1'b1, a, 8'h5A, 16'h0);
        for (int a = 0; a < 32; a++) cyc(1'b0, a, 8'h00, 16'h0);

        // R5: sticky set, write 0 keeps, write 1 clears
        cyc(1'b1, 6, 8'hFF, 16'h0019);
        cyc(1'b0, 4, 8'h00, 16'h0);
        chk("R5 sticky set", rdata, 8'h19);
        cyc(1'b1, 4, 8'h00, 16'h0);
        cyc(1'b1, 4, 8'h08, 16'h0);
        cyc(1'b0, 4, 8'h00, 16'h0);
        chk("R5 w1c", rdata, 8'h11);

        // R6: clear collides with set
        tag_ovr = "R6";
        cyc(1'b1, 4, 8'h19, 16'h0001);
        cyc(1'b0, 4, 8'h00, 16'h0);
        chk("R6 set wins", rdata[0], 1'b1);

        // R7: level bits follow, writes ignored
        tag_ovr = "R7";
        cyc(1'b1, 5, 8'hFF, 16'hA0C2);
        cyc(1'b1, 5, 8'hFF, 16'h0);
        cyc(1'b0, 5, 8'h00, 16'h0);
        chk("R7 level", rdata, 8'h00);
        tag_ovr = "";

        // R8: polarity flip and masking
        cyc(1'b1, 0, 8'h20, 16'h0);
        cyc(1'b1, 6, 8'h00, 16'h0);
        cyc(1'b1, 7, 8'h00, 16'h0);
        cyc(1'b0, 0, 8'h00, 16'h0);
        chk("R8 masked high-pol", irq, 1'b0);
        cyc(1'b1, 6, 8'h01, 16'h0);
        cyc(1'b0, 0, 8'h00, 16'h0);
        chk("R8 pending high-pol", irq, 1'b1);
        cyc(1'b1, 0, 8'h00, 16'h0);
        cyc(1'b0, 0, 8'h00, 16'h0);
        chk("R8 pending low-pol", irq, 1'b0);

        // R9: enable combinations, retrigger
        cyc(1'b1, 3, 8'h84, 16'h0);
        cyc(1'b0, 3, 8'h00, 16'h0);
        chk("R9 only first", {rst_a, rst_b, rdata[7]}, 3'b101);
        cyc(1'b0, 3, 8'h00, 16'h0);
        chk("R9 expired", {rst_a, rst_b, rdata[7]}, 3'b000);
        cyc(1'b1, 3, 8'h88, 16'h0);
        cyc(1'b1, 3, 8'h8C, 16'h0);
        cyc(1'b1, 3, 8'h0C, 16'h0);
        chk("R9 retrigger both", {rst_a, rst_b}, 2'b11);
        cyc(1'b1, 3, 8'h80, 16'h0);
        cyc(1'b0, 3, 8'h00, 16'h0);
        chk("R9 none enabled", {rst_a, rst_b}, 2'b00);

        // random traffic, weighted toward the reset and interrupt offsets
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            int a = (r < 2) ? 3 : (r < 4) ? 4 : $urandom_range(0, 31);
            logic [15:0] s = 16'($urandom) & (($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'hFFE6);
            if (n % 97 == 0) begin
                xstat = $urandom;
                finfo = {$urandom, $urandom};
            end
            cyc(1'($urandom_range(0, 1)), a, 8'($urandom), s);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule